// File: doc/BRIEF.md
# Pipelined Shift-Add Lifting Step

This block is one arithmetic step of a wavelet lifting network. It takes two neighbouring samples `a` and `b` and an update operand `acc`, and it returns `floor((acc·256 + C·(a+b)) / 256)`. `C` is a fixed constant with eight fractional bits, given as a parameter. The same unit can therefore serve as any of the predict, update or scaling steps of an irreversible 9/7 lifting chain. The surrounding network chooses `C` for each instance.

There is no multiplier. The pair sum `s = a + b` is formed first. The product `C·s` is then built from shifted copies of `s`, one for each set bit of the constant's `CW`-bit two's-complement pattern. The copy at the sign position is subtracted as a negative partial product. After the partial products, `acc` is scaled by 256 and added. An arithmetic right shift by eight gives the integer result.

Every register stage holds exactly one adder, so the longest path is a single add. A new operand set can be accepted every cycle. A small tag travels alongside each operand set, and a valid flag marks the cycle in which a result appears. The reset `rst_n` asserts asynchronously and is expected to be released in step with `clk`.

Top module: `lift_step_pipe`

## Requirements
- R1: When `valid_o` is high, `res_o` holds `floor((acc·256 + C·(a+b)) / 256)` reduced to `OUT_W` bits in two's complement, for the operands that entered with the matching `valid_i`. The default is C = −406, which is the 10-bit pattern 10.01101010.
- R2: Each accepted input produces exactly one `valid_o` pulse, `N+1` rising edges after the edge that samples it. `N` is the number of ones in the `CW`-bit two's-complement pattern of C. The default gives 6 cycles, and C = 226 gives 5.
- R3: Inputs may arrive on consecutive cycles with no gaps. Results leave one per cycle in the order of arrival, and none is lost.
- R4: `valid_o` is low while `rst_n` is low. After release it stays low until the first result is due.
- R5: While `valid_i` is low, the operand and tag inputs have no effect. While `valid_o` is low, `res_o` and `tag_o` keep their last values.
- R6: The `tag_i` value sampled with an input appears on `tag_o` in the same cycle as that input's result.
- R7: The final shift rounds toward minus infinity. With C = −406, the input (a=1, b=0, acc=0) gives −2, and (a=−1, b=0, acc=0) gives 1.
- R8: Full-range signed operands, for example a = b = acc = −128 or a = b = acc = 127 at 8 bits, give the exact result with no internal wrap.
- R9: C is a parameter. A positive constant such as 226 (00.11100010) works with the same structure, and in that case no negative partial product is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| valid_i | input | 1 | Operand set present this cycle |
| a_i | input | IN_W | First neighbour sample, signed |
| b_i | input | IN_W | Second neighbour sample, signed |
| acc_i | input | ACC_W | Operand updated by the step, signed |
| tag_i | input | TAG_W | Side-band label carried with the operands |
| valid_o | output | 1 | Result present this cycle |
| res_o | output | OUT_W | Updated value, signed |
| tag_o | output | TAG_W | Label of the result on `res_o` |

## Verification
The assertions take several things for granted. `valid_i` is never unknown after reset, and reset is applied before the first operand set. `C` fits its `CW`-bit pattern with at least one set bit, and `OUT_W` is wide enough for the result range, so the reduced model value and the datapath agree. The stimulus stays inside these limits. Operands are always full-range signed values of their declared widths. Both constants used, −406 and 226, fit 10 bits. The default output width covers the largest magnitude these constants can produce. Reset is held for several edges before the first operand set.

// File: rtl/lsp_pkg.sv
`timescale 1ns/1ps
package lsp_pkg;

  // Binary point position of the step constant.
  localparam int FRAC_BITS = 8;

  // Number of ones in the cw-bit two's-complement pattern of coef.
  function automatic int coef_term_count(input int coef, input int cw);
    int n;
    n = 0;
    for (int i = 0; i < cw; i++) begin
      if (((coef >>> i) & 1) == 1) n++;
    end
    return n;
  endfunction

  // Bit position of the idx-th one of the pattern, counted from the LSB.
  function automatic int coef_term_pos(input int coef, input int cw, input int idx);
    int n;
    int p;
    n = 0;
    p = 0;
    for (int i = 0; i < cw; i++) begin
      if (((coef >>> i) & 1) == 1) begin
        if (n == idx) p = i;
        n++;
      end
    end
    return p;
  endfunction

endpackage

// File: rtl/lsp_pair_sum.sv
`timescale 1ns/1ps
// First adder: sum of the two neighbour samples, one guard bit wider.
module lsp_pair_sum #(
  parameter int IN_W = 8
) (
  input  logic                   clk,
  input  logic                   en_i,
  input  logic signed [IN_W-1:0] a_i,
  input  logic signed [IN_W-1:0] b_i,
  output logic signed [IN_W:0]   s_o
);

  logic signed [IN_W:0] s_d;

  always_comb begin
    s_d = (IN_W+1)'(a_i) + (IN_W+1)'(b_i);
  end

  always_ff @(posedge clk) begin
    if (en_i) s_o <= s_d;
  end

endmodule

// File: rtl/lsp_delay.sv
`timescale 1ns/1ps
// Valid chain with matching side-band registers; data loads only with valid.
module lsp_delay #(
  parameter int W     = 12,
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [W-1:0]     dat_i,
  output logic [DEPTH-1:0] vld_o,
  output logic [W-1:0]     dat_o
);

  logic         v_at [DEPTH+1];
  logic [W-1:0] d_at [DEPTH+1];

  assign v_at[0] = vld_i;
  assign d_at[0] = dat_i;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic         v_d, v_q;
    logic [W-1:0] d_q;

    always_comb v_d = v_at[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    always_ff @(posedge clk) begin
      if (v_at[i]) d_q <= d_at[i];
    end

    assign v_at[i+1] = v_q;
    assign d_at[i+1] = d_q;
    assign vld_o[i]  = v_at[i+1];
  end

  assign dat_o = d_at[DEPTH];

endmodule

// File: rtl/lsp_term_chain.sv
`timescale 1ns/1ps
// Constant product as a chain of shifted partial products of s,
// one adder per register stage. The term at the sign position is negative.
module lsp_term_chain
  import lsp_pkg::*;
#(
  parameter int SW   = 9,
  parameter int CW   = 10,
  parameter int COEF = -406,
  parameter int PW   = SW + CW,
  localparam int NT  = coef_term_count(COEF, CW),
  localparam int CE  = (NT > 1) ? NT - 1 : 1
) (
  input  logic                 clk,
  input  logic [CE-1:0]        stg_en,
  input  logic signed [SW-1:0] s_i,
  output logic signed [PW-1:0] p_o
);

  function automatic logic signed [PW-1:0] term(input logic signed [SW-1:0] s, input int idx);
    int pos;
    logic signed [PW-1:0] e;
    pos = coef_term_pos(COEF, CW, idx);
    e   = PW'(s) <<< pos;
    return (pos == CW - 1) ? -e : e;
  endfunction

  logic signed [SW-1:0] s_at [CE];
  logic signed [PW-1:0] p_at [NT];

  assign s_at[0] = s_i;
  assign p_at[0] = term(s_i, 0);

  for (genvar j = 1; j < NT; j++) begin : g_add
    logic signed [PW-1:0] p_d, p_q;

    always_comb p_d = p_at[j-1] + term(s_at[j-1], j);

    always_ff @(posedge clk) begin
      if (stg_en[j-1]) p_q <= p_d;
    end

    assign p_at[j] = p_q;

    if (j < NT - 1) begin : g_fwd
      logic signed [SW-1:0] s_q;
      always_ff @(posedge clk) begin
        if (stg_en[j-1]) s_q <= s_at[j-1];
      end
      assign s_at[j] = s_q;
    end
  end

  assign p_o = p_at[NT-1];

endmodule

// File: rtl/lsp_acc_merge.sv
`timescale 1ns/1ps
// Last adder: pre-scaled update operand plus product, then floor shift.
module lsp_acc_merge #(
  parameter int ACC_W = 8,
  parameter int PW    = 19,
  parameter int OUT_W = 11,
  parameter int TAG_W = 4,
  parameter int FRAC  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic [TAG_W-1:0]        tag_i,
  input  logic signed [PW-1:0]    p_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] res_o,
  output logic [TAG_W-1:0]        tag_o
);

  localparam int FW = ((PW > ACC_W + FRAC) ? PW : ACC_W + FRAC) + 1;

  logic signed [FW-1:0] f_d, f_q;
  logic                 v_q;
  logic [TAG_W-1:0]     t_q;

  always_comb begin
    f_d = (FW'(acc_i) <<< FRAC) + FW'(p_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= en_i;
  end

  always_ff @(posedge clk) begin
    if (en_i) begin
      f_q <= f_d;
      t_q <= tag_i;
    end
  end

  assign valid_o = v_q;
  assign res_o   = OUT_W'(f_q >>> FRAC);
  assign tag_o   = t_q;

endmodule

// File: rtl/lift_step_pipe.sv
`timescale 1ns/1ps
module lift_step_pipe #(
  parameter int IN_W  = 8,
  parameter int ACC_W = 8,
  parameter int OUT_W = 11,
  parameter int TAG_W = 4,
  parameter int CW    = 10,
  parameter int COEF  = -406
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid_i,
  input  logic signed [IN_W-1:0]  a_i,
  input  logic signed [IN_W-1:0]  b_i,
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic [TAG_W-1:0]        tag_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] res_o,
  output logic [TAG_W-1:0]        tag_o
);
  import lsp_pkg::*;

  localparam int SW = IN_W + 1;
  localparam int PW = SW + CW;
  localparam int NT = coef_term_count(COEF, CW);
  localparam int CE = (NT > 1) ? NT - 1 : 1;
  localparam int DW = TAG_W + ACC_W;

  logic signed [SW-1:0] pair_s;
  logic [NT-1:0]        stg_vld;
  logic [DW-1:0]        side_q;
  logic signed [PW-1:0] prod;

  lsp_pair_sum #(.IN_W(IN_W)) u_pair (
    .clk  (clk),
    .en_i (valid_i),
    .a_i  (a_i),
    .b_i  (b_i),
    .s_o  (pair_s)
  );

  lsp_delay #(.W(DW), .DEPTH(NT)) u_side (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (valid_i),
    .dat_i ({tag_i, acc_i}),
    .vld_o (stg_vld),
    .dat_o (side_q)
  );

  lsp_term_chain #(.SW(SW), .CW(CW), .COEF(COEF), .PW(PW)) u_chain (
    .clk    (clk),
    .stg_en (stg_vld[CE-1:0]),
    .s_i    (pair_s),
    .p_o    (prod)
  );

  lsp_acc_merge #(
    .ACC_W (ACC_W),
    .PW    (PW),
    .OUT_W (OUT_W),
    .TAG_W (TAG_W),
    .FRAC  (FRAC_BITS)
  ) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (stg_vld[NT-1]),
    .acc_i   ($signed(side_q[ACC_W-1:0])),
    .tag_i   (side_q[DW-1:ACC_W]),
    .p_i     (prod),
    .valid_o (valid_o),
    .res_o   (res_o),
    .tag_o   (tag_o)
  );

endmodule

// File: rtl/lsp_checker.sv
`timescale 1ns/1ps
module lsp_checker
  import lsp_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int ACC_W = 8,
  parameter int OUT_W = 11,
  parameter int TAG_W = 4,
  parameter int CW    = 10,
  parameter int COEF  = -406
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    valid_i,
  input logic signed [IN_W-1:0]  a_i,
  input logic signed [IN_W-1:0]  b_i,
  input logic signed [ACC_W-1:0] acc_i,
  input logic [TAG_W-1:0]        tag_i,
  input logic                    valid_o,
  input logic signed [OUT_W-1:0] res_o,
  input logic [TAG_W-1:0]        tag_o
);

  localparam int LAT = coef_term_count(COEF, CW) + 1;

  // Plain arithmetic model, no shift-add structure.
  function automatic logic signed [OUT_W-1:0] model(
    input logic signed [IN_W-1:0] a, input logic signed [IN_W-1:0] b,
    input logic signed [ACC_W-1:0] acc);
    longint t;
    t = (longint'(acc) <<< FRAC_BITS) + longint'(COEF) * (longint'(a) + longint'(b));
    return OUT_W'(t >>> FRAC_BITS);
  endfunction

  logic [LAT-1:0]          rv;
  logic signed [OUT_W-1:0] re [LAT];
  logic [TAG_W-1:0]        rt [LAT];
  logic                    armed, seen_out, rst_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv       <= '0;
      armed    <= 1'b0;
      seen_out <= 1'b0;
    end else begin
      rv    <= {rv[LAT-2:0], valid_i};
      armed <= 1'b1;
      if (valid_o) seen_out <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    re[0] <= model(a_i, b_i, acc_i);
    rt[0] <= tag_i;
    for (int k = 1; k < LAT; k++) begin
      re[k] <= re[k-1];
      rt[k] <= rt[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rst_seen <= 1'b1;
  end

  // R4: no result flag while reset is held
  always @(negedge clk) begin
    if (!rst_n && rst_seen === 1'b1) begin
      assert_reset_quiet_R4: assert (!valid_o)
        else $error("valid_o high during reset");
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (valid_o == rv[LAT-1]));

  assert_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && valid_o) |-> (res_o == re[LAT-1]));

  assert_tag_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && valid_o) |-> (tag_o == rt[LAT-1]));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_out && !valid_o) |-> ($stable(res_o) && $stable(tag_o)));

endmodule

bind lift_step_pipe lsp_checker #(
  .IN_W(IN_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .TAG_W(TAG_W), .CW(CW), .COEF(COEF)
) u_lsp_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
  .acc_i(acc_i), .tag_i(tag_i), .valid_o(valid_o), .res_o(res_o), .tag_o(tag_o)
);

// File: tb/sim_lift_step_pipe.sv
`timescale 1ns/1ps
module sim_lift_step_pipe;

  localparam int C0 = -406;  // negative constant, sign term used
  localparam int C1 = 226;   // positive constant (R9)

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic              valid_i;
  logic signed [7:0] a_i, b_i, acc_i;
  logic [3:0]        tag_i;
  logic              v0, v1;
  logic signed [10:0] r0, r1;
  logic [3:0]        t0, t1;

  lift_step_pipe #(.COEF(C0)) u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .acc_i(acc_i), .tag_i(tag_i), .valid_o(v0), .res_o(r0), .tag_o(t0));

  lift_step_pipe #(.COEF(C1)) u1 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .acc_i(acc_i), .tag_i(tag_i), .valid_o(v1), .res_o(r1), .tag_o(t1));

  int tests = 0;
  int fails = 0;
  int    q0[$], q1[$], qt[$];
  string ql0[$], ql1[$];

  function automatic int ref_out(int c, int a, int b, int acc);
    longint t;
    t = longint'(acc) * 256 + longint'(c) * longint'(a + b);
    return int'(t >>> 8);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(int a, int b, int acc, int tag, string req);
    @(negedge clk);
    valid_i = 1'b1;
    a_i = 8'(a); b_i = 8'(b); acc_i = 8'(acc); tag_i = 4'(tag);
    q0.push_back(ref_out(C0, a, b, acc));
    q1.push_back(ref_out(C1, a, b, acc));
    qt.push_back(tag & 15);
    ql0.push_back(req);
    ql1.push_back({req, "/R9"});
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  // Scoreboard: results leave in input order (R3), values (R1), tags (R6).
  int tq0[$], tq1[$];
  always @(negedge clk) begin
    if (rst_n) begin
      if (v0) begin
        if (q0.size() == 0) check(1'b0, "R2 u0 unexpected result", 1, 0);
        else begin
          string l;
          int e;
          e = q0.pop_front();
          l = ql0.pop_front();
          check(int'(r0) == e, {l, " u0 value"}, int'(r0), e);
          tq0.push_back(int'(t0));
        end
      end
      if (v1) begin
        if (q1.size() == 0) check(1'b0, "R2 u1 unexpected result", 1, 0);
        else begin
          string l;
          int e;
          e = q1.pop_front();
          l = ql1.pop_front();
          check(int'(r1) == e, {l, " u1 value"}, int'(r1), e);
          tq1.push_back(int'(t1));
        end
      end
      // R6: both instances see the same tag stream
      while (tq0.size() > 0 && tq1.size() > 0 && qt.size() > 0) begin
        int et;
        int g0;
        int g1;
        et = qt.pop_front();
        g0 = tq0.pop_front();
        g1 = tq1.pop_front();
        check(g0 == et, "R6 u0 tag", g0, et);
        check(g1 == et, "R6 u1 tag", g1, et);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lat0, lat1, cnt0, cnt1, exp_lat0, exp_lat1;
    logic signed [10:0] h0, h1;
    logic [3:0] ht0;

    exp_lat0 = $countones(10'(C0)) + 1;  // 6
    exp_lat1 = $countones(10'(C1)) + 1;  // 5

    rst_n = 1'b0; valid_i = 1'b0;
    a_i = '0; b_i = '0; acc_i = '0; tag_i = '0;
    repeat (4) begin
      @(negedge clk);
      check(!v0 && !v1, "R4 during reset", int'(v0) + int'(v1), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(!v0 && !v1, "R4 after release", int'(v0) + int'(v1), 0);
    end

    // R2: latency and single pulse per input
    drive(3, 5, 10, 9, "R2");
    lat0 = 0; lat1 = 0; cnt0 = 0; cnt1 = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      valid_i = 1'b0;
      if (v0) begin cnt0++; if (lat0 == 0) lat0 = k; end
      if (v1) begin cnt1++; if (lat1 == 0) lat1 = k; end
    end
    check(lat0 == exp_lat0, "R2 u0 latency", lat0, exp_lat0);
    check(lat1 == exp_lat1, "R2 u1 latency", lat1, exp_lat1);
    check(cnt0 == 1, "R2 u0 pulse count", cnt0, 1);
    check(cnt1 == 1, "R2 u1 pulse count", cnt1, 1);

    // R5: operand changes with valid_i low are ignored; outputs hold
    h0 = r0; h1 = r1; ht0 = t0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(!v0 && r0 == h0 && t0 == ht0, "R5 u0 hold", int'(r0), int'(h0));
      check(!v1 && r1 == h1, "R5 u1 hold", int'(r1), int'(h1));
      valid_i = 1'b0;
      a_i = 8'(k * 53 - 100); b_i = 8'(k * 29 + 7); acc_i = 8'(-k * 17); tag_i = 4'(k);
    end

    // R7 floor rounding, R8 extreme operands
    drive(1, 0, 0, 1, "R7");
    drive(-1, 0, 0, 2, "R7");
    drive(0, 1, -3, 3, "R7");
    drive(-128, -128, -128, 4, "R8");
    drive(127, 127, 127, 5, "R8");
    drive(-128, -128, 127, 6, "R8");
    drive(127, 127, -128, 7, "R8");
    drive(-128, 127, 0, 8, "R8");
    drive(0, 0, -128, 9, "R8");
    drive(0, 0, 127, 10, "R8");
    idle(10);

    // R3: back-to-back sweep over every (a, b) pair
    for (int n = 0; n < 65536; n++) begin
      logic [15:0] nn;
      nn = 16'(n);
      if ((n % 4096) == 4095) idle(1);
      drive(int'($signed(nn[15:8])), int'($signed(nn[7:0])),
            int'($signed(8'(n * 37 + 11))), n, "R1/R3");
    end
    idle(14);
    check(q0.size() == 0, "R3 u0 drained", q0.size(), 0);
    check(q1.size() == 0, "R3 u1 drained", q1.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule